// File: doc/BRIEF.md
# Dual-Channel USB Host Transfer Launcher

This block sits between a CPU register bus and a USB host packet engine. It holds two independent transfer descriptor sets, A and B. Each set has a host control byte and an 8-bit buffer base pointer. Software fills in a descriptor and sets its Enable and Arm bits. The block then decides when that descriptor is handed to the packet engine. It can optionally hold the hand-off until just after the next start-of-frame strobe. When both sets are ready in the same cycle, set A goes first.

The engine is modelled as a request/busy/done handshake. A one-cycle `eng_req` pulse carries the descriptor fields. The engine reports `eng_done` when the transfer ends. On that completion the block clears the Arm bit of the set that was in flight. It also raises a sticky per-set done flag, and these flags drive the `irq` output. A global `low_speed` input qualifies two things: it suppresses the preamble request, and it makes the frame-sync hold ineffective.

Top module: `usb_xfer_launcher`

## Requirements
- R1: Address map. Set A's control byte is at 0x0 and its base pointer at 0x1. Set B's control byte is at 0x8 and its base pointer at 0x9. The done status register is at 0xD. Registers read back what was written. Every other address reads 0.
- R2: Control byte bits are Enable = bit1 and Arm = bit0. A set is launched only when both are 1. While Enable is 0, a set with Arm = 1 is never launched and stays armed.
- R3: SyncSOF is bit5. When it is 1 in full-speed mode, an armed and enabled set waits for a `sof_pulse` that arrives after arming. Its `eng_req` then rises on the second clock edge after that strobe. When SyncSOF is 0, launch happens as soon as the engine is free.
- R4: When `eng_done` ends a transfer, the Arm bit of that set reads 0. On the same edge, that set's done flag is set and `irq` becomes 1.
- R5: The status register at 0xD holds the done flags: bit0 for set A and bit1 for set B. Writing 1 to a bit clears it. `irq` is the OR of the flags.
- R6: Direction is bit2 (1 = OUT, 0 = IN) and appears on `eng_out`. ISO is bit4 and appears on `eng_iso`. The Data Toggle (bit6) appears on `eng_toggle` only for OUT transfers; it is 0 for IN transfers.
- R7: Preamble is bit7. In full speed (`low_speed` = 0) it appears on `eng_pre`. With `low_speed` = 1, `eng_pre` is 0 and SyncSOF is ignored, so the set launches without a strobe.
- R8: The set's base pointer, written before arming, appears on `eng_base` with the launch. `eng_set` names the set: 0 for A, 1 for B.
- R9: If both sets become eligible in the same cycle, set A is launched first. Set B is launched after A completes, and neither is lost.
- R10: Control bit3 is reserved and always reads 0.
- R11: Writing a control byte with Arm = 1 while that set is in flight does not start a second launch. The completion still clears Arm.
- R12: `eng_req` is a single-cycle pulse. It is never raised while `eng_busy` was high or while a transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | DATA_W (8) | Register write data |
| reg_rdata | output | DATA_W (8) | Combinational read data for `reg_addr` |
| low_speed | input | 1 | Global low-speed bus mode |
| sof_pulse | input | 1 | One-cycle start-of-frame strobe from the frame timer |
| eng_busy | input | 1 | Packet engine is occupied |
| eng_done | input | 1 | One-cycle completion from the packet engine |
| eng_req | output | 1 | One-cycle launch pulse |
| eng_set | output | SET_W (1) | Index of the launched set |
| eng_out | output | 1 | 1 = OUT transfer, 0 = IN transfer |
| eng_toggle | output | 1 | DATA1 when 1 (OUT only) |
| eng_pre | output | 1 | Send a preamble before the packet |
| eng_iso | output | 1 | Isochronous packet |
| eng_base | output | DATA_W (8) | Buffer base pointer |
| irq | output | 1 | OR of the sticky done flags |

## Verification
The assertions rely on the engine behaving as a well-formed handshake. `eng_done` is a single-cycle pulse, raised only for a transfer that was launched, and `sof_pulse` lasts one cycle. The bench's engine model guarantees both. It raises busy on the first falling edge that sees a request, keeps busy high for four cycles, and ends the transfer with exactly one done pulse. All inputs are driven on falling edges. The frame strobe is issued only by a dedicated task that makes it one cycle long.

// File: rtl/usb_xfer_pkg.sv
package usb_xfer_pkg;

   // Host control byte, MSB first; bit positions are software-visible.
   typedef struct packed {
      logic pre;    // bit7
      logic tog;    // bit6
      logic sync;   // bit5
      logic iso;    // bit4
      logic rsvd;   // bit3
      logic out;    // bit2
      logic en;     // bit1
      logic arm;    // bit0
   } hc_ctrl_t;

   localparam int CTRL_OFS = 0;
   localparam int BASE_OFS = 1;

endpackage

// File: rtl/usb_xfer_desc.sv
module usb_xfer_desc
   import usb_xfer_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_base,
   input  logic [DATA_W-1:0] wdata,
   input  logic              low_speed,
   input  logic              sof_pulse,
   input  logic              busy_self,
   input  logic              done_self,
   output hc_ctrl_t          ctrl_q,
   output logic [DATA_W-1:0] base_q,
   output logic              eligible
);

   hc_ctrl_t wr_val;
   logic     sof_seen_q;
   logic     pending;
   logic     need_sof;

   always_comb begin
      wr_val      = hc_ctrl_t'(wdata[7:0]);
      wr_val.rsvd = 1'b0;
      if (busy_self) wr_val.arm = ctrl_q.arm;   // no restart while in flight
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q     <= wr_val;
         if (done_self) ctrl_q.arm <= 1'b0;      // completion wins
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (wr_base) base_q <= wdata;
   end

   assign pending  = ctrl_q.arm & ctrl_q.en & ~busy_self;
   assign need_sof = ctrl_q.sync & ~low_speed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sof_seen_q <= 1'b0;
      else if (!pending)  sof_seen_q <= 1'b0;
      else if (sof_pulse) sof_seen_q <= 1'b1;
   end

   assign eligible = pending & (~need_sof | sof_seen_q);

endmodule

// File: rtl/usb_xfer_arb.sv
module usb_xfer_arb #(
   parameter  int N         = 2,
   parameter  bit LOW_FIRST = 1'b1,
   localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (req[i]) idx = IW'(i);
         end
      end else begin : g_high_first
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (req[i]) idx = IW'(i);
         end
      end
   endgenerate

   assign any = |req;

endmodule

// File: rtl/usb_xfer_launcher.sv
module usb_xfer_launcher
   import usb_xfer_pkg::*;
#(
   parameter  int ADDR_W      = 4,
   parameter  int DATA_W      = 8,
   parameter  int NUM_SETS    = 2,
   parameter  int SET_STRIDE  = 8,
   parameter  int STATUS_ADDR = 13,
   parameter  bit A_FIRST     = 1'b1,
   localparam int SET_W       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              low_speed,
   input  logic              sof_pulse,
   input  logic              eng_busy,
   input  logic              eng_done,
   output logic              eng_req,
   output logic [SET_W-1:0]  eng_set,
   output logic              eng_out,
   output logic              eng_toggle,
   output logic              eng_pre,
   output logic              eng_iso,
   output logic [DATA_W-1:0] eng_base,
   output logic              irq
);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("DATA_W must be 8 to hold the control byte");
      end
      if (NUM_SETS < 1 || NUM_SETS > DATA_W) begin : g_bad_sets
         $error("NUM_SETS must be 1..DATA_W");
      end
      if (NUM_SETS * SET_STRIDE > (1 << ADDR_W)) begin : g_bad_map
         $error("descriptor sets exceed address space");
      end
      if ((STATUS_ADDR % SET_STRIDE) <= BASE_OFS) begin : g_bad_status
         $error("status address collides with a descriptor register");
      end
   endgenerate

   hc_ctrl_t            ctrl_arr [NUM_SETS];
   logic [DATA_W-1:0]   base_arr [NUM_SETS];
   logic [NUM_SETS-1:0] elig;
   logic [NUM_SETS-1:0] arm_vec;
   logic [NUM_SETS-1:0] done_q;
   logic [NUM_SETS-1:0] done_set;
   logic [NUM_SETS-1:0] done_clr;
   logic                inflight_q;
   logic [SET_W-1:0]    infl_set_q;
   logic                any_elig;
   logic [SET_W-1:0]    gnt_idx;
   logic                launch;
   logic                done_acc;
   logic                status_wr;

   assign done_acc  = eng_done & inflight_q;
   assign status_wr = reg_we && (reg_addr == ADDR_W'(STATUS_ADDR));

   generate
      for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
         logic busy_i, done_i, wr_c, wr_b;
         assign busy_i = inflight_q && (infl_set_q == SET_W'(i));
         assign done_i = done_acc   && (infl_set_q == SET_W'(i));
         assign wr_c   = reg_we && (reg_addr == ADDR_W'(i * SET_STRIDE + CTRL_OFS));
         assign wr_b   = reg_we && (reg_addr == ADDR_W'(i * SET_STRIDE + BASE_OFS));

         usb_xfer_desc #(.DATA_W(DATA_W)) desc_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (wr_c),
            .wr_base   (wr_b),
            .wdata     (reg_wdata),
            .low_speed (low_speed),
            .sof_pulse (sof_pulse),
            .busy_self (busy_i),
            .done_self (done_i),
            .ctrl_q    (ctrl_arr[i]),
            .base_q    (base_arr[i]),
            .eligible  (elig[i])
         );

         assign arm_vec[i]  = ctrl_arr[i].arm;
         assign done_set[i] = done_i;
         assign done_clr[i] = status_wr & reg_wdata[i];
      end
   endgenerate

   usb_xfer_arb #(.N(NUM_SETS), .LOW_FIRST(A_FIRST)) arb_i (
      .req (elig),
      .any (any_elig),
      .idx (gnt_idx)
   );

   assign launch = any_elig & ~inflight_q & ~eng_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight_q <= 1'b0;
         infl_set_q <= '0;
         eng_req    <= 1'b0;
         eng_set    <= '0;
         eng_out    <= 1'b0;
         eng_toggle <= 1'b0;
         eng_pre    <= 1'b0;
         eng_iso    <= 1'b0;
         eng_base   <= '0;
      end else begin
         eng_req <= launch;
         if (launch) begin
            inflight_q <= 1'b1;
            infl_set_q <= gnt_idx;
            eng_set    <= gnt_idx;
            eng_out    <= ctrl_arr[gnt_idx].out;
            eng_toggle <= ctrl_arr[gnt_idx].out & ctrl_arr[gnt_idx].tog;
            eng_pre    <= ctrl_arr[gnt_idx].pre & ~low_speed;
            eng_iso    <= ctrl_arr[gnt_idx].iso;
            eng_base   <= base_arr[gnt_idx];
         end else if (done_acc) begin
            inflight_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= '0;
      else        done_q <= (done_q & ~done_clr) | done_set;
   end

   assign irq = |done_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(STATUS_ADDR)) begin
         reg_rdata[NUM_SETS-1:0] = done_q;
      end else begin
         for (int i = 0; i < NUM_SETS; i++) begin
            if (reg_addr == ADDR_W'(i * SET_STRIDE + CTRL_OFS)) reg_rdata = DATA_W'(ctrl_arr[i]);
            if (reg_addr == ADDR_W'(i * SET_STRIDE + BASE_OFS)) reg_rdata = base_arr[i];
         end
      end
   end

endmodule

// File: rtl/usb_xfer_launcher_chk.sv
module usb_xfer_launcher_chk #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int NUM_SETS = 2,
   parameter int SET_W    = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                eng_req,
   input logic                eng_busy,
   input logic                eng_done,
   input logic                eng_out,
   input logic                eng_toggle,
   input logic                eng_pre,
   input logic                low_speed,
   input logic                irq,
   input logic                inflight_q,
   input logic [SET_W-1:0]    infl_set_q,
   input logic [NUM_SETS-1:0] arm_vec,
   input logic [NUM_SETS-1:0] done_q
);

   // R12: launch is a lone pulse
   p_req_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> !eng_req);

   // R12: never launch into a busy engine
   p_no_launch_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> !$past(eng_busy));

   // R12: launch always marks a transfer in flight
   p_req_sets_flight_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> inflight_q);

   // R7: preamble never requested in low-speed mode
   p_no_pre_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> !(eng_pre && $past(low_speed)));

   // R6: IN transfers carry no toggle
   p_in_no_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_out) |-> !eng_toggle);

   // R4: completion raises the interrupt
   p_done_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && inflight_q) |=> irq);

   // R5: interrupt only when some flag is set
   p_irq_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done_q != '0));

   generate
      for (genvar i = 0; i < NUM_SETS; i++) begin : g_arm
         // R4: completion clears that set's Arm
         p_arm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_done && inflight_q && infl_set_q == SET_W'(i)) |=> !arm_vec[i]);
      end
   endgenerate

endmodule

bind usb_xfer_launcher usb_xfer_launcher_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_SETS (NUM_SETS),
   .SET_W    (SET_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .eng_req    (eng_req),
   .eng_busy   (eng_busy),
   .eng_done   (eng_done),
   .eng_out    (eng_out),
   .eng_toggle (eng_toggle),
   .eng_pre    (eng_pre),
   .low_speed  (low_speed),
   .irq        (irq),
   .inflight_q (inflight_q),
   .infl_set_q (infl_set_q),
   .arm_vec    (arm_vec),
   .done_q     (done_q)
);

// File: tb/usb_xfer_launcher_tb_top.sv
module usb_xfer_launcher_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       low_speed = 1'b0;
   logic       sof_pulse = 1'b0;
   logic       eng_busy = 1'b0;
   logic       eng_done = 1'b0;
   logic       eng_req;
   logic [0:0] eng_set;
   logic       eng_out, eng_toggle, eng_pre, eng_iso, irq;
   logic [7:0] eng_base;

   int errors = 0;
   int checks = 0;
   int req_cnt = 0;
   int busy_cnt = 0;
   bit finished = 0;
   logic [12:0] exp_q[$];   // {set, out, toggle, pre, iso, base}

   always #(CLK_PERIOD / 2) clk = ~clk;

   usb_xfer_launcher dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .low_speed(low_speed),
      .sof_pulse(sof_pulse), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_req(eng_req), .eng_set(eng_set), .eng_out(eng_out),
      .eng_toggle(eng_toggle), .eng_pre(eng_pre), .eng_iso(eng_iso),
      .eng_base(eng_base), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   // Monitor + engine model: pops the scoreboard on every launch.
   always @(negedge clk) begin
      eng_done <= 1'b0;
      if (rst_n && eng_req) begin
         logic [12:0] act;
         act = {eng_set, eng_out, eng_toggle, eng_pre, eng_iso, eng_base};
         req_cnt++;
         if (exp_q.size() == 0) begin
            chk(0, "R2/R3/R11 unexpected launch", act, 0);
         end else begin
            logic [12:0] e;
            e = exp_q.pop_front();
            chk(act == e, "R6/R7/R8/R9 launch descriptor", act, e);
         end
         eng_busy <= 1'b1;
         busy_cnt <= 4;
      end else if (busy_cnt != 0) begin
         busy_cnt <= busy_cnt - 1;
         if (busy_cnt == 1) begin
            eng_done <= 1'b1;
            eng_busy <= 1'b0;
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == e, tag, reg_rdata, e);
   endtask

   task automatic sof;
      @(negedge clk);
      sof_pulse = 1'b1;
      @(negedge clk);
      sof_pulse = 1'b0;
   endtask

   task automatic push(input bit s, o, t, p, i, input logic [7:0] b);
      exp_q.push_back({s, o, t, p, i, b});
   endtask

   task automatic wait_idle;
      int n = 0;
      while (n < 200 && !(exp_q.size() == 0 && busy_cnt == 0 && !eng_req && !eng_busy)) begin
         @(negedge clk);
         n++;
      end
      chk(n < 200, "R9 pending launch never issued", exp_q.size(), 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int base_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(eng_req == 0, "R12 reset eng_req", eng_req, 0);
      chk(irq == 0, "R4 reset irq", irq, 0);
      rd_chk(4'h0, 8'h00, "R1 reset ctrl A");

      // R1 map, R10 reserved bit
      wr(4'h1, 8'h5A);
      wr(4'h9, 8'hC3);
      rd_chk(4'h1, 8'h5A, "R1 base A readback");
      rd_chk(4'h9, 8'hC3, "R1 base B readback");
      wr(4'h0, 8'h08);
      rd_chk(4'h0, 8'h00, "R10 reserved bit A");
      wr(4'h8, 8'hFC);
      rd_chk(4'h8, 8'hF4, "R10 reserved bit B");
      rd_chk(4'h3, 8'h00, "R1 unused address");
      wr(4'h8, 8'h00);

      // R2: armed but disabled is ignored
      wr(4'h0, 8'h01);
      repeat (10) @(negedge clk);
      chk(req_cnt == 0, "R2 no launch with Enable=0", req_cnt, 0);
      rd_chk(4'h0, 8'h01, "R2 stays armed");

      // OUT on A with DATA1
      push(0, 1, 1, 0, 0, 8'h5A);
      wr(4'h0, 8'h47);
      wait_idle();
      rd_chk(4'h0, 8'h46, "R4 arm cleared on done");
      chk(irq == 1, "R4 irq after done", irq, 1);
      rd_chk(4'hD, 8'h01, "R5 status A flag");
      wr(4'hD, 8'h01);
      chk(irq == 0, "R5 irq after clear", irq, 0);
      rd_chk(4'hD, 8'h00, "R5 status cleared");

      // IN on B with toggle set and ISO: toggle suppressed
      push(1, 0, 0, 0, 1, 8'hC3);
      wr(4'h8, 8'h53);
      wait_idle();
      rd_chk(4'hD, 8'h02, "R5 status B flag");
      wr(4'hD, 8'h02);

      // R7 preamble, full speed
      push(0, 1, 0, 1, 0, 8'h5A);
      wr(4'h0, 8'h87);
      wait_idle();
      // R7 low speed: preamble dropped and SyncSOF ignored
      low_speed = 1'b1;
      wr(4'h1, 8'h33);
      push(0, 1, 0, 0, 0, 8'h33);
      wr(4'h0, 8'hA7);
      wait_idle();
      chk(req_cnt == 4, "R7 low-speed launch without SOF", req_cnt, 4);
      low_speed = 1'b0;
      wr(4'hD, 8'h03);

      // R3 SyncSOF waits for strobe
      base_cnt = req_cnt;
      wr(4'h0, 8'h27);
      repeat (12) @(negedge clk);
      chk(req_cnt == base_cnt, "R3 held until SOF", req_cnt, base_cnt);
      push(0, 1, 0, 0, 0, 8'h33);
      @(negedge clk);
      sof_pulse = 1'b1;
      @(negedge clk);
      sof_pulse = 1'b0;
      chk(eng_req == 0, "R3 no req one edge after SOF", eng_req, 0);
      @(negedge clk);
      chk(eng_req == 1, "R3 req two edges after SOF", eng_req, 1);
      wait_idle();
      wr(4'hD, 8'h03);

      // R9 both eligible on the same strobe: A then B
      wr(4'h0, 8'h27);
      wr(4'h8, 8'h23);
      push(0, 1, 0, 0, 0, 8'h33);
      push(1, 0, 0, 0, 0, 8'hC3);
      sof();
      wait_idle();
      rd_chk(4'hD, 8'h03, "R9 both sets completed");
      wr(4'hD, 8'h03);

      // R11 re-arm while in flight
      base_cnt = req_cnt;
      push(0, 1, 0, 0, 0, 8'h33);
      wr(4'h0, 8'h07);
      @(negedge clk);
      wr(4'h0, 8'h07);
      wait_idle();
      chk(req_cnt == base_cnt + 1, "R11 single launch", req_cnt, base_cnt + 1);
      rd_chk(4'h0, 8'h06, "R11 arm cleared after completion");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule